// File: doc/BRIEF.md
# Half-Bridge Complementary PWM with Dead-Band

This block turns one timer and one duty threshold into a pair of complementary drive signals for a half-bridge of power switches. A primary output is active for the first part of each PWM period and a secondary output for the rest. Whenever either output enters its active window, its turn-on is held back by a programmable dead-band of 0 to 127 enable ticks. Turn-off is never delayed, so the two switches are never conducting together.

The timer advances only on a one-cycle instruction-cycle enable pulse, not on every clock. The period, duty and dead-band inputs are taken into working copies only when a period ends. Software can therefore change them at any time without producing a short or torn pulse.

Each output reaches its pin only while its drive enable is set. An undriven pin reads low, and the enable is passed on to the pad as its drive signal.

Top module: `hbp_top`

## Requirements
- R1: The timer advances by one only on a cycle with `tick` high. When it equals the latched period value it returns to 0 on the next tick, so one PWM period is period+1 ticks long.
- R2: With dead-band 0 and 0 < duty < period, the primary output is high for timer values below duty and the secondary output is high for every other timer value.
- R3: When an output enters its active window, it goes high only after `dead` further ticks, at timer index window_start+dead. When the window ends it goes low on the same edge.
- R4: If the dead-band is greater than or equal to the length of an output's active window, that output stays low for the whole window.
- R5: The primary and secondary outputs are never high in the same cycle.
- R6: With duty 0, the primary output never goes high. The secondary output is high continuously once its initial dead-band after reset has elapsed.
- R7: With duty greater than or equal to period, the secondary output never goes high. The primary output is high continuously once its initial dead-band after reset has elapsed.
- R8: New period, duty and dead-band input values take effect only when the current period ends.
- R9: `pin_pri` and `pin_sec` equal their output only while `oe_pri` and `oe_sec` are high, and read 0 otherwise. `drv_pri` and `drv_sec` follow `oe_pri` and `oe_sec`.
- R10: A synchronous reset drives both pins low and clears the timer and the latched settings. The first tick after reset starts a new period with the current inputs, and both outputs count their dead-band from that point.
- R11: Clock cycles without `tick` change neither output, nor the timer, nor the dead-band count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Instruction-cycle enable pulse |
| period_in | input | 8 | Period value (period is value+1 ticks) |
| duty_in | input | 8 | Primary active window length in ticks |
| dead_in | input | 7 | Dead-band delay in ticks |
| oe_pri | input | 1 | Drive enable for the primary pin |
| oe_sec | input | 1 | Drive enable for the secondary pin |
| pin_pri | output | 1 | Primary PWM pin value |
| pin_sec | output | 1 | Secondary (complement) PWM pin value |
| drv_pri | output | 1 | Pad drive enable, primary |
| drv_sec | output | 1 | Pad drive enable, secondary |

## Verification
The bench targets these corner cases:
- **Dead-band equal to or longer than a window.** A design that clamps the delay instead would leak a one-tick sliver where no pulse is allowed.
- **Duty of zero and duty at or above the period.** A design that treats the period wrap as a phase change would re-apply the dead-band every period and chop a continuous output.
- **Duty changed in mid-period.** A design without the boundary latch would cut the running pulse early.
- **Reset in mid-pulse, and long gaps between ticks.** A design that lets the secondary output start straight out of reset would fire a switch with no dead-band. A design that counts raw clocks would shorten every delay.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
    parameter int CNT_W = 8;
    parameter int DB_W  = 7;
    localparam int NSIDE = 2;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [DB_W-1:0]  db_t;

    typedef enum logic {
        SIDE_PRI = 1'b0,
        SIDE_SEC = 1'b1
    } side_e;

    typedef struct packed {
        cnt_t period;
        cnt_t duty;
        db_t  dead;
    } cfg_t;

    // Raw (pre-dead-band) primary window for a given timer value and settings
    function automatic logic pri_window(cnt_t t, cfg_t c);
        if (c.duty == '0)
            return 1'b0;
        if (c.duty >= c.period)
            return 1'b1;
        return (t < c.duty);
    endfunction
endpackage

// File: rtl/hbp_cfg_shadow.sv
module hbp_cfg_shadow
    import hbp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cfg_t cfg_in,
    output cfg_t cfg_q,
    output cfg_t cfg_nxt
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (load)
            cfg_q <= cfg_in;
    end

    assign cfg_nxt = load ? cfg_in : cfg_q;
endmodule

// File: rtl/hbp_timebase.sv
module hbp_timebase
    import hbp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  cnt_t period_q,
    output cnt_t timer_q,
    output cnt_t timer_nxt,
    output logic wrap
);
    assign wrap = tick && (timer_q == period_q);

    always_comb begin
        if (!tick)
            timer_nxt = timer_q;
        else if (wrap)
            timer_nxt = '0;
        else
            timer_nxt = timer_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            timer_q <= '0;
        else
            timer_q <= timer_nxt;
    end
endmodule

// File: rtl/hbp_deadband.sv
module hbp_deadband
    import hbp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic win_nxt,
    input  db_t  dead_nxt,
    output logic out_on
);
    logic was_on;
    db_t  cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            was_on <= 1'b0;
            cnt_q  <= '0;
        end else if (tick) begin
            was_on <= win_nxt;
            if (win_nxt && !was_on)
                cnt_q <= dead_nxt;
            else if (win_nxt && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
            else if (!win_nxt)
                cnt_q <= '0;
        end
    end

    assign out_on = was_on && (cnt_q == '0);
endmodule

// File: rtl/hbp_pindrive.sv
module hbp_pindrive (
    input  logic sig_on,
    input  logic oe,
    output logic pin,
    output logic drv
);
    assign pin = oe & sig_on;
    assign drv = oe;
endmodule

// File: rtl/hbp_top.sv
module hbp_top
    import hbp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic [CNT_W-1:0]      period_in,
    input  logic [CNT_W-1:0]      duty_in,
    input  logic [DB_W-1:0]       dead_in,
    input  logic                  oe_pri,
    input  logic                  oe_sec,
    output logic                  pin_pri,
    output logic                  pin_sec,
    output logic                  drv_pri,
    output logic                  drv_sec
);
    cfg_t cfg_in, cfg_q, cfg_nxt;
    cnt_t timer_q, timer_nxt;
    logic wrap;
    logic pri_nxt;
    logic [NSIDE-1:0] win_nxt, on_vec, oe_vec, pin_vec, drv_vec;
    logic pri_on, sec_on;
    db_t  dead_q;
    cnt_t period_q;

    assign cfg_in = '{period: period_in, duty: duty_in, dead: dead_in};

    hbp_timebase u_tb (
        .clk(clk), .rst(rst), .tick(tick), .period_q(cfg_q.period),
        .timer_q(timer_q), .timer_nxt(timer_nxt), .wrap(wrap)
    );

    hbp_cfg_shadow u_cfg (
        .clk(clk), .rst(rst), .load(wrap), .cfg_in(cfg_in),
        .cfg_q(cfg_q), .cfg_nxt(cfg_nxt)
    );

    assign pri_nxt            = pri_window(timer_nxt, cfg_nxt);
    assign win_nxt[SIDE_PRI]  = pri_nxt;
    assign win_nxt[SIDE_SEC]  = ~pri_nxt;
    assign oe_vec[SIDE_PRI]   = oe_pri;
    assign oe_vec[SIDE_SEC]   = oe_sec;

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        hbp_deadband u_db (
            .clk(clk), .rst(rst), .tick(tick), .win_nxt(win_nxt[s]),
            .dead_nxt(cfg_nxt.dead), .out_on(on_vec[s])
        );
        hbp_pindrive u_pd (
            .sig_on(on_vec[s]), .oe(oe_vec[s]),
            .pin(pin_vec[s]), .drv(drv_vec[s])
        );
    end

    assign pri_on   = on_vec[SIDE_PRI];
    assign sec_on   = on_vec[SIDE_SEC];
    assign dead_q   = cfg_q.dead;
    assign period_q = cfg_q.period;
    assign pin_pri  = pin_vec[SIDE_PRI];
    assign pin_sec  = pin_vec[SIDE_SEC];
    assign drv_pri  = drv_vec[SIDE_PRI];
    assign drv_sec  = drv_vec[SIDE_SEC];
endmodule

// File: rtl/hbp_checker.sv
module hbp_checker
    import hbp_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic tick,
    input logic pri_on,
    input logic sec_on,
    input logic pin_pri,
    input logic pin_sec,
    input cnt_t timer_q,
    input cnt_t period_q,
    input db_t  dead_q
);
    AST_BOTH_NEVER_ON: assert property (@(posedge clk) disable iff (rst)
        !(pri_on && sec_on)); // R5

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(pri_on) && $stable(sec_on) && $stable(timer_q))); // R11

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (tick && timer_q == period_q) |=> (timer_q == '0)); // R1

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!pin_pri && !pin_sec)); // R10

    AST_PRI_GAP: assert property (@(posedge clk) disable iff (rst)
        ($rose(pri_on) && dead_q != '0) |-> !$past(sec_on)); // R3

    AST_SEC_GAP: assert property (@(posedge clk) disable iff (rst)
        ($rose(sec_on) && dead_q != '0) |-> !$past(pri_on)); // R3
endmodule

bind hbp_top hbp_checker u_chk (
    .clk(clk), .rst(rst), .tick(tick), .pri_on(pri_on), .sec_on(sec_on),
    .pin_pri(pin_pri), .pin_sec(pin_sec), .timer_q(timer_q),
    .period_q(period_q), .dead_q(dead_q)
);

// File: tb/sim_hbp_top.sv
module sim_hbp_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 11;
    // each entry: {period[22:15], duty[14:7], dead[6:0]}
    localparam logic [22:0] VEC [NV] = '{
        {8'd9,  8'd4,  7'd1},
        {8'd9,  8'd4,  7'd0},
        {8'd9,  8'd4,  7'd4},
        {8'd9,  8'd3,  7'd7},
        {8'd9,  8'd0,  7'd2},
        {8'd9,  8'd9,  7'd3},
        {8'd9,  8'd12, 7'd0},
        {8'd15, 8'd8,  7'd2},
        {8'd5,  8'd2,  7'd127},
        {8'd3,  8'd1,  7'd0},
        {8'd0,  8'd0,  7'd0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic [7:0] period_in = '0;
    logic [7:0] duty_in = '0;
    logic [6:0] dead_in = '0;
    logic oe_pri = 1'b1;
    logic oe_sec = 1'b1;
    logic pin_pri, pin_sec, drv_pri, drv_sec;
    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hbp_top u0 (
        .clk(clk), .rst(rst), .tick(tick), .period_in(period_in),
        .duty_in(duty_in), .dead_in(dead_in), .oe_pri(oe_pri), .oe_sec(oe_sec),
        .pin_pri(pin_pri), .pin_sec(pin_sec), .drv_pri(drv_pri), .drv_sec(drv_sec)
    );

    task automatic chk(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic do_tick;
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic do_reset;
        @(negedge clk) begin rst = 1'b1; tick = 1'b0; end
        @(negedge clk);
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic setup(input int p, input int d, input int db);
        period_in = p[7:0]; duty_in = d[7:0]; dead_in = db[6:0];
    endtask

    // k = number of ticks since reset (k >= 1); timer t = (k-1) mod (P+1)
    function automatic logic exp_pri(int p, int d, int db, int k);
        int t = (k-1) % (p+1);
        logic first = (k-1) < (p+1);
        if (d == 0) return 1'b0;
        if (d >= p) return first ? (t >= db) : 1'b1;
        return (t < d) && (t >= db);
    endfunction

    function automatic logic exp_sec(int p, int d, int db, int k);
        int t = (k-1) % (p+1);
        logic first = (k-1) < (p+1);
        if (d == 0) return first ? (t >= db) : 1'b1;
        if (d >= p) return 1'b0;
        return (t >= d) && ((t - d) >= db);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // table walk
        for (int v = 0; v < NV; v++) begin
            int p = int'(VEC[v][22:15]);
            int d = int'(VEC[v][14:7]);
            int db = int'(VEC[v][6:0]);
            string tag;
            if (d == 0) tag = "R6";
            else if (d >= p) tag = "R7";
            else if (db >= d || db >= p + 1 - d) tag = "R4";
            else tag = "R3";
            oe_pri = 1'b1; oe_sec = 1'b1;
            setup(p, d, db);
            do_reset;
            chk("R10", pin_pri, 1'b0, "pri after reset");
            chk("R10", pin_sec, 1'b0, "sec after reset");
            for (int k = 1; k <= 3*(p+1); k++) begin
                do_tick;
                chk(tag, pin_pri, exp_pri(p, d, db, k), $sformatf("pri v=%0d k=%0d", v, k));
                chk(tag, pin_sec, exp_sec(p, d, db, k), $sformatf("sec v=%0d k=%0d", v, k));
                chk("R5", pin_pri && pin_sec, 1'b0, "overlap");
            end
        end

        // R1: rising edges of the primary pin are period+1 ticks apart
        begin
            int last = -1;
            logic prev = 1'b0;
            setup(4, 2, 0);
            do_reset;
            for (int k = 1; k <= 20; k++) begin
                do_tick;
                if (pin_pri && !prev) begin
                    if (last >= 0) chk("R1", (k - last) == 5, 1'b1, "period spacing");
                    last = k;
                end
                prev = pin_pri;
            end
        end

        // R2: plain complementary split with no dead-band
        setup(7, 3, 0);
        do_reset;
        for (int k = 1; k <= 8; k++) begin
            do_tick;
            chk("R2", pin_pri, (k-1) < 3, $sformatf("pri k=%0d", k));
            chk("R2", pin_sec, (k-1) >= 3, $sformatf("sec k=%0d", k));
        end

        // R8: duty changed mid-period takes effect at the next boundary
        setup(9, 4, 0);
        do_reset;
        repeat (3) do_tick;
        duty_in = 8'd8;
        repeat (3) do_tick;                     // k=6, t=5
        chk("R8", pin_pri, 1'b0, "old duty kept t=5");
        chk("R8", pin_sec, 1'b1, "old duty kept sec t=5");
        repeat (10) do_tick;                    // k=16, t=5 of second period
        chk("R8", pin_pri, 1'b1, "new duty t=5");
        repeat (3) do_tick;                     // k=19, t=8
        chk("R8", pin_pri, 1'b0, "new duty end t=8");
        chk("R8", pin_sec, 1'b1, "new duty sec t=8");

        // R9: pin gating by drive enables
        setup(9, 4, 0);
        oe_pri = 1'b0; oe_sec = 1'b1;
        do_reset;
        do_tick;                                // t=0, primary active
        chk("R9", pin_pri, 1'b0, "pri gated");
        chk("R9", drv_pri, 1'b0, "pri drive off");
        chk("R9", drv_sec, 1'b1, "sec drive on");
        @(negedge clk) oe_pri = 1'b1;
        #1;
        chk("R9", pin_pri, 1'b1, "pri ungated");
        oe_sec = 1'b0;
        repeat (5) do_tick;                     // t=5, secondary active
        chk("R9", pin_sec, 1'b0, "sec gated");
        chk("R9", drv_sec, 1'b0, "sec drive off");
        oe_sec = 1'b1;

        // R10: reset in mid-pulse, then restart with dead-band
        setup(9, 4, 2);
        do_reset;
        repeat (4) do_tick;                     // t=3, primary on
        chk("R3", pin_pri, 1'b1, "pri on before mid reset");
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        chk("R10", pin_pri, 1'b0, "pri forced low");
        chk("R10", pin_sec, 1'b0, "sec forced low");
        rst = 1'b0;
        do_tick;
        chk("R10", pin_pri, 1'b0, "restart k=1 delayed");
        do_tick;
        chk("R10", pin_pri, 1'b0, "restart k=2 delayed");
        do_tick;
        chk("R10", pin_pri, 1'b1, "restart k=3 on");

        // R11: idle clocks freeze outputs and the dead-band count
        repeat (6) @(negedge clk);
        chk("R11", pin_pri, 1'b1, "pri held while idle");
        do_tick;                                // t=3
        chk("R11", pin_pri, 1'b1, "pri t=3");
        do_tick;                                // t=4, secondary window starts
        chk("R11", pin_pri, 1'b0, "pri off t=4");
        chk("R11", pin_sec, 1'b0, "sec delayed t=4");
        repeat (6) @(negedge clk);
        chk("R11", pin_sec, 1'b0, "sec still delayed after idle");
        do_tick;                                // t=5
        chk("R11", pin_sec, 1'b0, "sec delayed t=5");
        do_tick;                                // t=6
        chk("R11", pin_sec, 1'b1, "sec on t=6");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule